// File: doc/BRIEF.md
# Selectable-Length Twisted-Ring Frequency Divider

This block is a chain of D flip-flops wired as a shift register whose first stage is fed with the complement of one chosen stage. Closing the loop at stage n makes a twisted ring of n bits. Each active bit then toggles as a square wave with a period of 2n clock cycles. A small selector input picks n while the block runs, so one instance can divide its clock by 2, 4, 6 or 8 with the default depth. A further selector position turns the loop into a fill: a constant one enters the chain, and every stage ends up high and stays there.

The whole chain is visible on the stage bus. The first stage doubles as the divided output, which is a registered data signal for downstream logic. When three stages are active the block also drives a three-phase bus: three square waves of equal duty, each lagging the one before it by one third of a period. A run guard watches the active part of the chain. If the bits there do not form a single contiguous run of ones or of zeros, the next edge clears the chain and counting restarts from the all-zero state. Such a pattern can appear after the selector lengthens the loop.

Top module: `johnson_divider`

## Requirements
- R1: A synchronous active-high reset clears every stage, so on the first cycle after reset stage_o is 0 and div_o is 0.
- R2: On every clock edge outside reset that does not apply a repair, stage i (for i at least 1) takes the previous value of stage i-1, inactive stages included.
- R3: With sel_i = k in 1..STAGES (ring mode), stage 0 takes the complement of stage k-1 on each edge. From reset, after j edges (j at most k), stage_o equals 2^j - 1.
- R4: In ring mode with sel_i = k, div_o (which is stage 0) is high for k cycles and low for k cycles, giving a period of 2k clocks.
- R5: A new sel_i value sets the loop length from the next clock edge, with no reset in between.
- R6: In ring mode, suppose the k active stages (bits k-1..0 of stage_o) hold values that change between neighbouring bits more than once. The next edge then sets all stages to zero, and the edge after that resumes the normal sequence from zero.
- R7: Any sel_i value outside 1..STAGES (the default fill code is STAGES+1 = 5, and 0, 6 and 7 act the same) feeds a constant one into stage 0 with no repair. After STAGES edges stage_o is all ones and div_o stays high.
- R8: When sel_i = 3, phase_o bit 0 is stage 0, bit 1 is stage 2 (a lag of 2 cycles, 120 degrees), and bit 2 is the complement of stage 1 (a lag of 4 cycles, 240 degrees). For any other sel_i, phase_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | SEL_W (3) | Loop length select: 1..STAGES ring, other values fill |
| stage_o | output | STAGES (4) | All stage bits, bit 0 is the first stage |
| div_o | output | 1 | Divided square-wave output (first stage) |
| phase_o | output | 3 | Three-phase outputs, active only when sel_i is 3 |

## Verification
Every flip-flop of the block drives stage_o directly. A corrupted bit therefore shows on the ports in the same cycle it is stored, and it is never hidden behind other logic. Suppose a corrupted pattern breaks the single-run rule in the active stages. It is visible for exactly one cycle, and stage_o reads zero on the next cycle. A wrong tap or feedback polarity shows within 2n clocks as a div_o high or low time that differs from n. A wrong stage order in the three-phase bus shows as a lag other than 2 or 4 cycles between its bits.

// File: rtl/jdiv_pkg.sv
package jdiv_pkg;

    localparam int LEN_W = 8;

    typedef enum logic {
        MODE_RING = 1'b0,
        MODE_FILL = 1'b1
    } loop_mode_e;

    typedef struct packed {
        loop_mode_e       mode;
        logic [LEN_W-1:0] len;
    } tap_cfg_t;

    function automatic tap_cfg_t make_cfg(int unsigned sel, int unsigned stages);
        tap_cfg_t c;
        if (sel >= 1 && sel <= stages) begin
            c.mode = MODE_RING;
            c.len  = LEN_W'(sel);
        end else begin
            c.mode = MODE_FILL;
            c.len  = LEN_W'(stages);
        end
        return c;
    endfunction

endpackage

// File: rtl/jdiv_tap_decode.sv
module jdiv_tap_decode
    import jdiv_pkg::*;
#(
    parameter int STAGES = 4,
    parameter int SEL_W  = 3
) (
    input  logic [SEL_W-1:0] sel_i,
    output tap_cfg_t         cfg_o
);
    always_comb begin
        cfg_o = make_cfg(32'(sel_i), STAGES);
    end
endmodule

// File: rtl/jdiv_run_guard.sv
module jdiv_run_guard
    import jdiv_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic [STAGES-1:0] state_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              legal_o
);
    localparam int N_EDGE = STAGES - 1;

    logic [N_EDGE-1:0] change;

    for (genvar i = 0; i < N_EDGE; i++) begin : g_edge
        assign change[i] = (state_i[i] ^ state_i[i+1]) && (32'(i + 1) < 32'(len_i));
    end

    // legal when at most one neighbour change among the active stages
    assign legal_o = ((change & (change - N_EDGE'(1))) == '0);
endmodule

// File: rtl/jdiv_chain.sv
module jdiv_chain
    import jdiv_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  tap_cfg_t          cfg_i,
    input  logic              legal_i,
    output logic [STAGES-1:0] state_o
);
    logic              tap_bit;
    logic              feed;
    logic [STAGES-1:0] state_d;

    always_comb begin
        tap_bit = 1'b0;
        for (int i = 0; i < STAGES; i++) begin
            if (cfg_i.len == LEN_W'(i + 1)) tap_bit = state_o[i];
        end
    end

    assign feed = (cfg_i.mode == MODE_FILL) ? 1'b1 : ~tap_bit;

    always_comb begin
        if (cfg_i.mode == MODE_RING && !legal_i) begin
            state_d = '0;
        end else begin
            state_d = {state_o[STAGES-2:0], feed};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_o <= '0;
        else     state_o <= state_d;
    end
endmodule

// File: rtl/jdiv_phase3.sv
module jdiv_phase3
    import jdiv_pkg::*;
(
    input  logic [2:0] low3_i,
    input  tap_cfg_t   cfg_i,
    output logic [2:0] phase_o
);
    logic active;

    assign active  = (cfg_i.mode == MODE_RING) && (cfg_i.len == LEN_W'(3));
    assign phase_o = active ? {~low3_i[1], low3_i[2], low3_i[0]} : 3'b000;
endmodule

// File: rtl/johnson_divider.sv
module johnson_divider
    import jdiv_pkg::*;
#(
    parameter int STAGES = 4,
    parameter int SEL_W  = $clog2(STAGES + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [STAGES-1:0] stage_o,
    output logic              div_o,
    output logic [2:0]        phase_o
);
    tap_cfg_t cfg;
    logic     legal;

    jdiv_tap_decode #(.STAGES(STAGES), .SEL_W(SEL_W)) u_dec (
        .sel_i (sel_i),
        .cfg_o (cfg)
    );

    jdiv_run_guard #(.STAGES(STAGES)) u_guard (
        .state_i (stage_o),
        .len_i   (cfg.len),
        .legal_o (legal)
    );

    jdiv_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .cfg_i   (cfg),
        .legal_i (legal),
        .state_o (stage_o)
    );

    jdiv_phase3 u_phase (
        .low3_i  (stage_o[2:0]),
        .cfg_i   (cfg),
        .phase_o (phase_o)
    );

    assign div_o = stage_o[0];
endmodule

// File: rtl/johnson_divider_chk.sv
module johnson_divider_chk #(
    parameter int STAGES = 4,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  sel_i,
    input logic [STAGES-1:0] stage_o,
    input logic              div_o,
    input logic [2:0]        phase_o
);
    logic in_ring;
    logic tap_bit;

    always_comb begin
        in_ring = (32'(sel_i) >= 1) && (32'(sel_i) <= STAGES);
        tap_bit = 1'b0;
        for (int i = 0; i < STAGES; i++) begin
            if (32'(sel_i) == i + 1) tap_bit = stage_o[i];
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (stage_o == '0));

    a_r2_shift_or_clear: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stage_o[STAGES-1:1] == $past(stage_o[STAGES-2:0])) || (stage_o == '0)));

    a_r3_ring_feedback: assert property (@(posedge clk) disable iff (rst)
        in_ring |=> ((stage_o[0] == ~$past(tap_bit)) || (stage_o == '0)));

    a_r7_fill_feeds_one: assert property (@(posedge clk) disable iff (rst)
        !in_ring |=> stage_o[0]);

    a_r7_fill_holds_high: assert property (@(posedge clk) disable iff (rst)
        (!in_ring && (stage_o == '1)) |=> div_o);

    a_r8_phase_idle: assert property (@(posedge clk) disable iff (rst)
        (32'(sel_i) != 3) |-> (phase_o == 3'b000));
endmodule

bind johnson_divider johnson_divider_chk #(.STAGES(STAGES), .SEL_W(SEL_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (sel_i),
    .stage_o (stage_o),
    .div_o   (div_o),
    .phase_o (phase_o)
);

// File: tb/johnson_divider_tb.sv
module johnson_divider_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STAGES = 4;
    localparam int SEL_W  = 3;

    // {sel, expected high cycles, expected low cycles}
    localparam int VEC [4][3] = '{
        '{1, 1, 1},
        '{2, 2, 2},
        '{3, 3, 3},
        '{4, 4, 4}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [SEL_W-1:0]  sel = 3'd1;
    logic [STAGES-1:0] stage;
    logic              div;
    logic [2:0]        phase;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    johnson_divider #(.STAGES(STAGES), .SEL_W(SEL_W)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (sel),
        .stage_o (stage),
        .div_o   (div),
        .phase_o (phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
        end
    end

    initial begin
        int hi;
        int lo;
        logic [2:0] rec [12];

        // R1: reset state
        @(negedge clk);
        do_reset();
        check(stage == 4'd0 && div == 1'b0, "R1 reset clears stages", int'(stage), 0);

        // R3/R4: table walk per loop length
        foreach (VEC[v]) begin
            sel = SEL_W'(VEC[v][0]);
            do_reset();
            for (int j = 1; j <= VEC[v][0]; j++) begin
                tick();
                check(stage == STAGES'((1 << j) - 1), "R3 fill sequence from reset",
                      int'(stage), (1 << j) - 1);
            end
            repeat (16) tick();
            for (int w = 0; w < 40 && div == 1'b1; w++) tick();
            for (int w = 0; w < 40 && div == 1'b0; w++) tick();
            hi = 0;
            while (div == 1'b1 && hi < 40) begin tick(); hi++; end
            lo = 0;
            while (div == 1'b0 && lo < 40) begin tick(); lo++; end
            check(hi == VEC[v][1], "R4 div_o high cycles", hi, VEC[v][1]);
            check(lo == VEC[v][2], "R4 div_o low cycles", lo, VEC[v][2]);
        end

        // R5: selector change applies at the next edge
        sel = 3'd4;
        do_reset();
        tick();
        tick();
        check(stage == 4'b0011, "R5 setup state", int'(stage), 3);
        sel = 3'd2;
        tick();
        check(stage == 4'b0110, "R5 new tap on next edge", int'(stage), 6);

        // R6: illegal pattern repaired after lengthening the loop
        sel = 3'd2;
        do_reset();
        repeat (3) tick();
        check(stage == 4'b0110, "R6 setup state", int'(stage), 6);
        sel = 3'd4;
        tick();
        check(stage == 4'b0000, "R6 repair to zero", int'(stage), 0);
        tick();
        check(stage == 4'b0001, "R6 resumes sequence", int'(stage), 1);

        // R7: fill mode from a running state
        sel = 3'd5;
        repeat (STAGES) tick();
        check(stage == 4'b1111, "R7 fill reaches all ones", int'(stage), 15);
        repeat (3) tick();
        check(stage == 4'b1111 && div, "R7 fill holds high", int'(stage), 15);
        sel = 3'd0;
        do_reset();
        repeat (STAGES) tick();
        check(stage == 4'b1111, "R7 code 0 fills", int'(stage), 15);
        sel = 3'd7;
        do_reset();
        tick();
        check(stage == 4'b0001, "R7 code 7 first edge", int'(stage), 1);

        // R8: three-phase relationship
        sel = 3'd3;
        do_reset();
        repeat (12) tick();
        for (int t = 0; t < 12; t++) begin
            rec[t] = phase;
            tick();
        end
        hi = 0;
        for (int t = 0; t < 6; t++) hi += int'(rec[t][0]);
        check(hi == 3, "R8 phase duty", hi, 3);
        for (int t = 4; t < 12; t++) begin
            check(rec[t][1] == rec[t-2][0], "R8 phase b lags 120 degrees",
                  int'(rec[t][1]), int'(rec[t-2][0]));
            check(rec[t][2] == rec[t-4][0], "R8 phase c lags 240 degrees",
                  int'(rec[t][2]), int'(rec[t-4][0]));
        end
        sel = 3'd4;
        tick();
        check(phase == 3'b000, "R8 phase idle outside three-stage mode", int'(phase), 0);

        // R2: shift of inactive stages in a short loop
        sel = 3'd1;
        do_reset();
        repeat (3) tick();
        check(stage == 4'b0101, "R2 inactive stages shift", int'(stage), 5);

        done = 1;
        summary();
    end
endmodule